// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the serial front end of a small sensor register space. It listens on a two-wire I2C bus as a target at 7-bit address 0x1E in standard and fast mode, decodes write and read transactions, and turns them into byte accesses on a register space of thirteen locations.

A write transaction loads an internal byte-wide address pointer from its first data byte. Every later byte of that transaction goes to the register the pointer names, and the pointer then moves on. A read transaction returns the register at the pointer, and the pointer moves on after each byte.

The pointer never counts past the last sample register. After location 8 it jumps back to location 3, so a host that keeps reading gets the three sample axes over and over. The pointer itself cannot be read.

The three configuration registers (locations 0 to 2) and the three identity bytes (locations 10 to 12) live inside the block. The sample and status registers (locations 3 to 9) belong to the surrounding logic. The block reaches them through a read strobe and an address, and it samples `reg_rdata_i` combinationally in the strobe cycle.

Both bus lines pass through a synchroniser and a glitch filter that run on the system clock. SDA is driven open-drain. Bus accesses are served at once and never wait on measurement activity: the block never stretches the clock.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 0x1E (0x3C writes, 0x3D reads). On any other address it drives nothing and ignores the rest of the transaction until the next START.
- R2: In a write transaction the first byte after the address loads the pointer. A write with only that byte changes no register.
- R3: Further write bytes go to successive locations. Location 0 keeps bits 6:0 (mask 0x7F), location 1 keeps bits 7:5 (mask 0xE0), and location 2 keeps bits 1:0 (mask 0x03). Undefined bits always read 0. Each such write pulses `reg_wr_o` with the address and the masked data.
- R4: Writes to locations 3 to 255 change nothing and give no write strobe, but the pointer still advances.
- R5: A read returns the byte at the pointer, and the pointer advances after each byte (ACK or NACK). Location 8 is followed by location 3, and location 255 is followed by location 0.
- R6: Locations 10, 11 and 12 read 0x48, 0x34 and 0x33. Locations 13 to 255 read 0x00.
- R7: After reset, locations 0, 1 and 2 hold 0x10, 0x20 and 0x01, and the pointer is 0.
- R8: The block pulls SDA low in the ninth clock after a matching address and after each received byte. It releases SDA during the host's acknowledge clock of a read, and stops returning data after a NACK.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START is accepted in any state.
- R10: Fetching a byte from locations 3 to 9 pulses `reg_rd_o` for one cycle with `reg_addr_o` equal to that location. The byte on `reg_rdata_i` in that cycle is the byte that goes out on the bus.
- R11: A pulse on SCL or SDA that lasts one system clock cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| reg_addr_o | output | 8 | Current pointer / register address |
| reg_rd_o | output | 1 | One-cycle fetch strobe for locations 3..9 |
| reg_wr_o | output | 1 | One-cycle write strobe for locations 0..2 |
| reg_wdata_o | output | 8 | Masked write data |
| reg_rdata_i | input | 8 | External data for locations 3..9 |
| cfg_meas_o | output | 8 | Location 0 contents |
| cfg_gain_o | output | 8 | Location 1 contents |
| cfg_mode_o | output | 8 | Location 2 contents |

## Verification
Every one of the 128 addresses is tried in write direction. This separates the single matching address from near misses that differ in one bit, and a trailing byte after each mismatch shows that the pointer is left untouched.

Configuration writes sweep a spread of byte values across all three writable locations. The values read back over the bus separate the per-location masks.

Long sequential reads from locations 0, 9 and 254 separate the 8-to-3 wrap, the identity bytes, the zero region and the 8-bit roll-over.

Single-cycle glitches on SCL and on SDA go into every bit of a transaction. They separate a filtered front end from one that would count false edges or see a false START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int PTR_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int NUM_CFG = 3;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam ptr_t SAMPLE_FIRST = 8'd3;
    localparam ptr_t SAMPLE_LAST  = 8'd8;
    localparam ptr_t EXT_LAST     = 8'd9;
    localparam ptr_t ID_FIRST     = 8'd10;
    localparam ptr_t ID_LAST      = 8'd12;

    typedef enum logic [2:0] {
        LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_WR, LS_WR_ACK, LS_RD, LS_RD_ACK
    } link_state_e;

    typedef struct packed {
        logic  ptr_load;
        logic  wr;
        logic  rd_adv;
        logic  fetch;
        byte_t data;
    } bank_req_t;

    function automatic byte_t cfg_reset_val(input int idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'h20;
            default: return 8'h01;
        endcase
    endfunction

    function automatic byte_t cfg_mask_val(input int idx);
        case (idx)
            0:       return 8'h7F;
            1:       return 8'hE0;
            default: return 8'h03;
        endcase
    endfunction

    function automatic byte_t id_val(input ptr_t p);
        if (p == ID_FIRST)         return 8'h48;
        else if (p == ID_FIRST + 8'd1) return 8'h34;
        else                       return 8'h33;
    endfunction

    function automatic ptr_t ptr_next(input ptr_t p);
        return (p == SAMPLE_LAST) ? SAMPLE_FIRST : ptr_t'(p + 8'd1);
    endfunction

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {(LAST+1){IDLE_VAL}};
            dout <= IDLE_VAL;
        end else begin
            pipe <= {pipe[LAST-1:0], din};
            if (pipe[LAST] == pipe[LAST-1])
                dout <= pipe[LAST];
        end
    end

endmodule

// File: rtl/i2c_link_engine.sv
module i2c_link_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h1E
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl,
    input  logic      sda,
    input  byte_t     rd_data,
    output bank_req_t req,
    output logic      sda_oe
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    link_state_e state;
    logic        scl_q, sda_q;
    logic [3:0]  cnt;
    byte_t       sh, tx, dbyte;
    logic        rw, first, nack;
    logic        ptr_ld_q, wr_q, rd_adv_q;

    logic ev_start, ev_stop, ev_rise, ev_fall, fetch;

    assign ev_start = scl && scl_q && sda_q && !sda;
    assign ev_stop  = scl && scl_q && !sda_q && sda;
    assign ev_rise  = scl && !scl_q;
    assign ev_fall  = !scl && scl_q;
    assign fetch    = ev_fall && !ev_start && !ev_stop &&
                      ((state == LS_ADDR_ACK && rw) || (state == LS_RD_ACK && !nack));

    always_comb begin
        req.ptr_load = ptr_ld_q;
        req.wr       = wr_q;
        req.rd_adv   = rd_adv_q;
        req.fetch    = fetch;
        req.data     = dbyte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LS_IDLE;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            dbyte    <= '0;
            rw       <= 1'b0;
            first    <= 1'b0;
            nack     <= 1'b0;
            sda_oe   <= 1'b0;
            ptr_ld_q <= 1'b0;
            wr_q     <= 1'b0;
            rd_adv_q <= 1'b0;
        end else begin
            scl_q    <= scl;
            sda_q    <= sda;
            ptr_ld_q <= 1'b0;
            wr_q     <= 1'b0;
            rd_adv_q <= 1'b0;
            if (ev_start) begin
                state  <= LS_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev_stop) begin
                state  <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    LS_ADDR: begin
                        if (ev_rise) begin
                            sh  <= {sh[6:0], sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev_fall && cnt == BITS_PER_BYTE) begin
                            if (sh[7:1] == TARGET_ADDR) begin
                                sda_oe <= 1'b1;
                                rw     <= sh[0];
                                state  <= LS_ADDR_ACK;
                            end else begin
                                state  <= LS_IDLE;
                            end
                        end
                    end
                    LS_ADDR_ACK: begin
                        if (ev_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= LS_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                                state  <= LS_WR;
                            end
                        end
                    end
                    LS_WR: begin
                        if (ev_rise) begin
                            sh  <= {sh[6:0], sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev_fall && cnt == BITS_PER_BYTE) begin
                            sda_oe <= 1'b1;
                            dbyte  <= sh;
                            state  <= LS_WR_ACK;
                            if (first) ptr_ld_q <= 1'b1;
                            else       wr_q     <= 1'b1;
                        end
                    end
                    LS_WR_ACK: begin
                        if (ev_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            first  <= 1'b0;
                            state  <= LS_WR;
                        end
                    end
                    LS_RD: begin
                        if (ev_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev_fall) begin
                            if (cnt == BITS_PER_BYTE) begin
                                sda_oe <= 1'b0;
                                state  <= LS_RD_ACK;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    LS_RD_ACK: begin
                        if (ev_rise) begin
                            nack     <= sda;
                            rd_adv_q <= 1'b1;
                        end else if (ev_fall) begin
                            if (!nack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                                state  <= LS_RD;
                            end else begin
                                state  <= LS_IDLE;
                            end
                        end
                    end
                    default: state <= LS_IDLE;
                endcase
            end
        end
    end

    // R8: nothing is driven while the link is idle or the host acknowledges
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
        (state == LS_IDLE) |-> !sda_oe);
    assert_host_ack_released_R8: assert property (@(posedge clk) disable iff (rst)
        (state == LS_RD_ACK) |-> !sda_oe);
    // R9: the target never moves SDA while SCL stays high (no false START/STOP)
    assert_oe_steady_scl_high_R9: assert property (@(posedge clk) disable iff (rst)
        (scl && scl_q) |-> $stable(sda_oe));
    // R2: pointer load and register write never coincide
    assert_load_or_write_R2: assert property (@(posedge clk) disable iff (rst)
        !(ptr_ld_q && wr_q));

endmodule

// File: rtl/reg_space.sv
module reg_space
    import i2c_tgt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  bank_req_t                req,
    input  byte_t                    ext_rdata,
    output ptr_t                     ptr,
    output byte_t                    rd_data,
    output logic                     reg_rd,
    output logic                     reg_wr,
    output byte_t                    reg_wdata,
    output logic [NUM_CFG-1:0][7:0]  cfg_q
);
    logic in_cfg, in_ext, in_id;

    assign in_cfg = (ptr < ptr_t'(NUM_CFG));
    assign in_ext = (ptr >= SAMPLE_FIRST) && (ptr <= EXT_LAST);
    assign in_id  = (ptr >= ID_FIRST) && (ptr <= ID_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < NUM_CFG; i++)
                cfg_q[i] <= cfg_reset_val(i);
        end else begin
            if (req.wr) begin
                for (int i = 0; i < NUM_CFG; i++)
                    if (ptr == ptr_t'(i))
                        cfg_q[i] <= req.data & cfg_mask_val(i);
            end
            if (req.ptr_load)
                ptr <= req.data;
            else if (req.wr || req.rd_adv)
                ptr <= ptr_next(ptr);
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (ptr == ptr_t'(i)) rd_data = cfg_q[i];
        if (in_ext) rd_data = ext_rdata;
        if (in_id)  rd_data = id_val(ptr);
    end

    assign reg_rd    = req.fetch && in_ext;
    assign reg_wr    = req.wr && in_cfg;
    assign reg_wdata = req.data & cfg_mask_val(int'(ptr[1:0]));

    // R5: a read advance from the last sample location lands on the first
    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (req.rd_adv && !req.ptr_load && ptr == SAMPLE_LAST) |=> (ptr == SAMPLE_FIRST));
    // R3: undefined bits stay clear whatever was written
    assert_undefined_bits_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0][7] == 1'b0) && (cfg_q[1][4:0] == 5'd0) && (cfg_q[2][7:2] == 6'd0));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h1E,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] reg_addr_o,
    output logic       reg_rd_o,
    output logic       reg_wr_o,
    output logic [7:0] reg_wdata_o,
    input  logic [7:0] reg_rdata_i,
    output logic [7:0] cfg_meas_o,
    output logic [7:0] cfg_gain_o,
    output logic [7:0] cfg_mode_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines, clean_lines;
    bank_req_t            req;
    byte_t                rd_data;
    ptr_t                 ptr;
    logic [NUM_CFG-1:0][7:0] cfg_q;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_filter #(.SYNC_STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) filt_i (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (clean_lines[g])
        );
    end

    i2c_link_engine #(.TARGET_ADDR(TARGET_ADDR)) link_i (
        .clk     (clk),
        .rst     (rst),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .rd_data (rd_data),
        .req     (req),
        .sda_oe  (sda_oe_o)
    );

    reg_space space_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .ext_rdata (reg_rdata_i),
        .ptr       (ptr),
        .rd_data   (rd_data),
        .reg_rd    (reg_rd_o),
        .reg_wr    (reg_wr_o),
        .reg_wdata (reg_wdata_o),
        .cfg_q     (cfg_q)
    );

    assign reg_addr_o = ptr;
    assign cfg_meas_o = cfg_q[0];
    assign cfg_gain_o = cfg_q[1];
    assign cfg_mode_o = cfg_q[2];

    // R4: write strobes only ever name a configuration location
    assert_wr_strobe_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> (reg_addr_o < 8'd3));
    // R10: fetch strobes only ever name an external location
    assert_rd_strobe_ext_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |-> (reg_addr_o >= 8'd3 && reg_addr_o <= 8'd9));
    // R10: strobes are single-cycle
    assert_rd_strobe_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |=> !reg_rd_o);

endmodule

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_rd, reg_wr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata, cfg_meas, cfg_gain, cfg_mode;
    wire  sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    int wr_cnt  = 0;
    logic oe_seen;
    logic [7:0] m_cfg [3];
    logic [7:0] mptr;

    always #2.5 clk = ~clk;

    assign reg_rdata = 8'hD0 | {4'h0, reg_addr[3:0]};

    i2c_reg_target dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .reg_addr_o(reg_addr), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
        .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
        .cfg_meas_o(cfg_meas), .cfg_gain_o(cfg_gain), .cfg_mode_o(cfg_mode)
    );

    always @(posedge clk) begin
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (reg_wr) wr_cnt <= wr_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int i);
        return (i == 0) ? 8'h7F : (i == 1) ? 8'hE0 : 8'h03;
    endfunction

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p == 8'd8) ? 8'd3 : p + 8'd1;
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] p);
        if (p < 8'd3)       return m_cfg[p[1:0]];
        else if (p <= 8'd9) return 8'hD0 | p;
        else if (p == 8'd10) return 8'h48;
        else if (p == 8'd11) return 8'h34;
        else if (p == 8'd12) return 8'h33;
        else                return 8'h00;
    endfunction

    task automatic send_bit(input logic b, input bit gl);
        tick(Q/2);
        sda_m = b;
        if (gl) begin
            tick(2); scl_m = 1'b1; tick(1); scl_m = 1'b0;
        end
        tick(Q/2);
        scl_m = 1'b1;
        if (gl && b) begin
            tick(Q/2); sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(Q/2);
        end else begin
            tick(Q);
        end
        oe_seen = sda_oe;
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(Q/2);
        sda_m = 1'b1;
        tick(Q/2);
        scl_m = 1'b1;
        tick(Q);
        b = sda_line;
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q/2); sda_m = 1'b1; tick(Q/2); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q/2); sda_m = 1'b0; tick(Q/2); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, input bit gl, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i], gl);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic read_byte(input bit host_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        send_bit(~host_ack, 1'b0);
    endtask

    task automatic wr_seq(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n);
        logic a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        write_byte(8'h3C, 1'b0, a); chk("R8 address ack on write", a, 1'b1);
        write_byte(p, 1'b0, a);     chk("R8 pointer byte ack", a, 1'b1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            write_byte(d[k], 1'b0, a); chk("R8 data byte ack", a, 1'b1);
            if (mptr < 8'd3) m_cfg[mptr[1:0]] = d[k] & mask_of(int'(mptr));
            mptr = nxt(mptr);
        end
        bus_stop();
    endtask

    task automatic rd_seq(input logic [7:0] p, input int n, input string tag);
        logic a;
        logic [7:0] v;
        int exp_rd;
        int rd0;
        bus_start();
        write_byte(8'h3C, 1'b0, a); chk("R8 ack before pointer", a, 1'b1);
        write_byte(p, 1'b0, a);     chk("R2 pointer ack", a, 1'b1);
        bus_start();
        write_byte(8'h3D, 1'b0, a); chk("R9 repeated START read ack", a, 1'b1);
        mptr = p;
        exp_rd = 0;
        rd0 = rd_cnt;
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, v);
            chk(tag, v, model_byte(mptr));
            chk("R8 released in host ack clock", oe_seen, 1'b0);
            if (mptr >= 8'd3 && mptr <= 8'd9) exp_rd++;
            mptr = nxt(mptr);
        end
        bus_stop();
        chk("R10 fetch strobe count", rd_cnt - rd0, exp_rd);
    endtask

    initial begin : main
        logic a;
        logic [7:0] v;
        int w0;
        m_cfg[0] = 8'h10; m_cfg[1] = 8'h20; m_cfg[2] = 8'h01;
        rst = 1'b1; tick(6); rst = 1'b0; tick(6);

        chk("R7 reset loc0", cfg_meas, 8'h10);
        chk("R7 reset loc1", cfg_gain, 8'h20);
        chk("R7 reset loc2", cfg_mode, 8'h01);
        chk("R7 reset pointer", reg_addr, 8'h00);
        chk("R8 released after reset", sda_oe, 1'b0);

        // R2: pointer-only write to location 0 leaves it intact
        w0 = wr_cnt;
        wr_seq(8'h00, 8'h00, 8'h00, 8'h00, 0);
        chk("R2 pointer-only write keeps loc0", cfg_meas, 8'h10);
        chk("R2 pointer-only write no strobe", wr_cnt - w0, 0);

        // R1: full address sweep in write direction
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            write_byte({ad[6:0], 1'b0}, 1'b0, a);
            chk("R1 address match", a, (ad == 'h1E));
            write_byte((ad == 'h1E) ? 8'h0A : 8'h00, 1'b0, a);
            chk("R1 follow byte ack only when addressed", a, (ad == 'h1E));
            bus_stop();
        end
        bus_start();
        write_byte(8'h3D, 1'b0, a); chk("R1 read address ack", a, 1'b1);
        read_byte(1'b0, v);         chk("R1 pointer untouched by other targets", v, 8'h48);
        bus_stop();
        bus_start();
        write_byte(8'h3F, 1'b0, a); chk("R1 read to other address ignored", a, 1'b0);
        bus_stop();

        // R3: masked write sweep over the three config locations
        for (int s = 0; s < 256; s += 17) begin
            logic [7:0] x;
            x = s[7:0];
            w0 = wr_cnt;
            wr_seq(8'h00, x, ~x, x ^ 8'h5A, 3);
            chk("R3 write strobes", wr_cnt - w0, 3);
            chk("R3 loc0 masked", cfg_meas, x & 8'h7F);
            chk("R3 loc1 masked", cfg_gain, (~x) & 8'hE0);
            chk("R3 loc2 masked", cfg_mode, (x ^ 8'h5A) & 8'h03);
            rd_seq(8'h00, 3, "R3 readback");
        end

        // R5/R10: long read from 0 crosses the 8->3 wrap
        rd_seq(8'h00, 13, "R5 sequential read with wrap");
        // R6: identity and zero region
        rd_seq(8'h09, 7, "R6 identity and invalid read");
        // R5: 8-bit roll-over
        rd_seq(8'hFE, 3, "R5 pointer roll-over");

        // R4: writes past location 2 ignored but pointer advances
        w0 = wr_cnt;
        wr_seq(8'h02, 8'h02, 8'h99, 8'h55, 3);
        chk("R4 only one strobe", wr_cnt - w0, 1);
        chk("R4 loc2 written", cfg_mode, 8'h02);
        bus_start();
        write_byte(8'h3D, 1'b0, a);
        read_byte(1'b0, v);
        chk("R4 pointer advanced over ignored writes", v, 8'hD5);
        bus_stop();
        wr_seq(8'h0A, 8'h00, 8'h00, 8'h00, 1);
        rd_seq(8'h0A, 1, "R4 identity not writable");
        wr_seq(8'h07, 8'hFF, 8'hFF, 8'hFF, 3);
        bus_start();
        write_byte(8'h3D, 1'b0, a);
        read_byte(1'b0, v);
        chk("R5 write pointer wraps 8->3", v, 8'hD4);
        bus_stop();

        // R8: NACK ends data; the next read continues after the advanced pointer
        wr_seq(8'h0A, 8'h00, 8'h00, 8'h00, 0);
        bus_start();
        write_byte(8'h3D, 1'b0, a);
        read_byte(1'b0, v);
        chk("R8 byte before NACK", v, 8'h48);
        tick(Q);
        chk("R8 released after NACK", sda_oe, 1'b0);
        bus_start();
        write_byte(8'h3D, 1'b0, a);
        chk("R9 repeated START after NACK", a, 1'b1);
        read_byte(1'b0, v);
        chk("R5 pointer advanced on NACK byte", v, 8'h34);
        bus_stop();

        // R11: single-cycle glitches on every bit
        bus_start();
        write_byte(8'h3C, 1'b1, a); chk("R11 address with glitches", a, 1'b1);
        write_byte(8'h0B, 1'b1, a); chk("R11 pointer with glitches", a, 1'b1);
        bus_stop();
        bus_start();
        write_byte(8'h3D, 1'b0, a);
        read_byte(1'b0, v);
        chk("R11 glitches had no effect", v, 8'h34);
        bus_stop();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule